// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass

This block sits between up to 32 peripheral interrupt lines and a parent interrupt controller. The connected sources are gated by one enable word. They are then folded into a small number of level outputs. Each of these outputs covers a group of sources chosen at build time by a group mask parameter. A live status word lets software see which connected sources are currently asserted, whatever their enable bits hold.

The lowest few lines, typically serial-port interrupts, each pass through a mux. When the line's forward bit is set, the raw level goes straight to a dedicated output, and the enable, status, group and wake logic never see it. When the forward bit is clear, the dedicated output stays low. The line then behaves like any other source and joins one chosen group.

A small register port exposes the enable word at offset 0x0, the status word at 0x4 and the forward word at 0x8. There are no set or clear aliases, so software updates the enable word by read-modify-write. While a suspend input is high, a wake request reports any enabled, non-forwarded source that is active.

Top module: `irq_fold_top`

## Requirements
- R1: After reset the enable word is 0, the forward word equals its reset parameter (0x7 by default), and every group, forward and wake output and the read data are 0.
- R2: A write to offset 0x0 replaces the whole enable word. Reading offset 0x0 returns the stored word, limited to the connected bits (0x000 to 0xFFF by default).
- R3: Unconnected bit positions (12 to 31 by default) read as zero in every register, and a source on such a line never reaches any output.
- R4: Offset 0x4 returns the live level of each connected, non-forwarded source regardless of the enable word. Writes to offset 0x4 change no register.
- R5: Group output g is high one clock after any source is active, enabled, non-forwarded and inside group g's mask. The defaults are 0xEB8 for group 0 and 0x140 for group 1.
- R6: Offset 0x8 holds the forward word. Only bits 0 to NUM_MUX-1 (0 to 2) are writable, and all other bits read as zero.
- R7: While forward bit i is set, fwd_irq[i] follows src_irq[i] one clock later, whatever the enable word holds. That line is then left out of status, groups and wake.
- R8: While forward bit i is clear, fwd_irq[i] stays low. Line i then appears in status, obeys its enable bit, and drives the group selected by MUX_GRP (group 0 by default).
- R9: wake_req is high one clock after suspend is high while any enabled, non-forwarded, connected source is active. Otherwise it is low.
- R10: Read data appears on the clock edge that samples reg_ren and holds until the next read. Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | 32 | Peripheral interrupt levels, active high |
| suspend | input | 1 | System in suspend; enables wake reporting |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| grp_irq | output | NUM_GRP | Aggregated group outputs to the parent |
| fwd_irq | output | NUM_MUX | Dedicated bypass outputs of the muxed lines |
| wake_req | output | 1 | Wake request during suspend |

## Verification
The bench toggles the forward bit of a muxed line and checks that the line moves between its dedicated output and the aggregated path. A design that left a forwarded line in status or wake, or that let it obey its enable bit, fails these checks. It drives sources on unconnected positions and writes all ones to every register. A design that let those bits through shows nonzero read data or a spurious group output. It writes to the status offset and to an unmapped offset, then reads the enable word back to catch a decode that aliases one register onto another. It also checks a source that sits in a group mask but is disabled, and the wake output with suspend both low and high.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    // Register selected by the current access
    typedef enum logic [1:0] {
        SEL_ENABLE,
        SEL_STATUS,
        SEL_FWD,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            4'h0:    s = SEL_ENABLE;
            4'h4:    s = SEL_STATUS;
            4'h8:    s = SEL_FWD;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_fold_regs.sv
module irq_fold_regs
    import irq_fold_pkg::*;
#(
    parameter logic [WORD_W-1:0] CONN_MASK = 32'h0000_0FFF,
    parameter logic [WORD_W-1:0] MUX_BITS  = 32'h0000_0007,
    parameter logic [WORD_W-1:0] FWD_INIT  = 32'h0000_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic              ren,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] status_in,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] fwd_q,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e          sel;
    logic [WORD_W-1:0] rd_mux;

    assign sel = decode_sel(addr);

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rd_mux = en_q;
            SEL_STATUS: rd_mux = status_in;
            SEL_FWD:    rd_mux = fwd_q;
            SEL_NONE:   rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            fwd_q <= FWD_INIT & MUX_BITS;
            rdata <= '0;
        end else begin
            if (wen) begin
                if (sel == SEL_ENABLE) en_q  <= wdata & CONN_MASK;
                if (sel == SEL_FWD)    fwd_q <= wdata & MUX_BITS;
            end
            if (ren) rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_fold_route.sv
module irq_fold_route
    import irq_fold_pkg::*;
#(
    parameter int                       NUM_GRP   = 2,
    parameter int                       NUM_MUX   = 3,
    parameter int                       MUX_GRP   = 0,
    parameter logic [NUM_GRP*WORD_W-1:0] GRP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [WORD_W-1:0]        CONN_MASK = 32'h0000_0FFF,
    parameter logic [WORD_W-1:0]        MUX_BITS  = 32'h0000_0007
) (
    input  logic [WORD_W-1:0]  src,
    input  logic [WORD_W-1:0]  en,
    input  logic [WORD_W-1:0]  fwd,
    output logic [WORD_W-1:0]  live,
    output logic [NUM_GRP-1:0] grp_raw,
    output logic [NUM_MUX-1:0] fwd_raw,
    output logic               wake_any
);

    logic [WORD_W-1:0] active;

    // Forwarded lines are invisible to the second-level logic
    assign live     = src & CONN_MASK & ~(fwd & MUX_BITS);
    assign active   = live & en;
    assign wake_any = |active;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [WORD_W-1:0] EFF_MASK =
            GRP_MASKS[g*WORD_W +: WORD_W] | ((g == MUX_GRP) ? MUX_BITS : '0);
        assign grp_raw[g] = |(active & EFF_MASK);
    end

    for (genvar i = 0; i < NUM_MUX; i++) begin : g_mux
        assign fwd_raw[i] = src[i] & fwd[i];
    end

endmodule

// File: rtl/irq_fold_top.sv
module irq_fold_top
    import irq_fold_pkg::*;
#(
    parameter int                       NUM_GRP   = 2,
    parameter int                       NUM_MUX   = 3,
    parameter int                       MUX_GRP   = 0,
    parameter logic [NUM_GRP*WORD_W-1:0] GRP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [WORD_W-1:0]        CONN_MASK = 32'h0000_0FFF,
    parameter logic [WORD_W-1:0]        FWD_INIT  = 32'h0000_0007
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        src_irq,
    input  logic               suspend,
    input  logic               reg_wen,
    input  logic               reg_ren,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_GRP-1:0] grp_irq,
    output logic [NUM_MUX-1:0] fwd_irq,
    output logic               wake_req
);

    localparam logic [WORD_W-1:0] MUX_BITS = WORD_W'((64'd1 << NUM_MUX) - 64'd1);

    logic [WORD_W-1:0]  en_q;
    logic [WORD_W-1:0]  fwd_q;
    logic [WORD_W-1:0]  live;
    logic [NUM_GRP-1:0] grp_raw;
    logic [NUM_MUX-1:0] fwd_raw;
    logic               wake_any;

    irq_fold_regs #(
        .CONN_MASK (CONN_MASK),
        .MUX_BITS  (MUX_BITS),
        .FWD_INIT  (FWD_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (reg_wen),
        .ren       (reg_ren),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .status_in (live),
        .en_q      (en_q),
        .fwd_q     (fwd_q),
        .rdata     (reg_rdata)
    );

    irq_fold_route #(
        .NUM_GRP   (NUM_GRP),
        .NUM_MUX   (NUM_MUX),
        .MUX_GRP   (MUX_GRP),
        .GRP_MASKS (GRP_MASKS),
        .CONN_MASK (CONN_MASK),
        .MUX_BITS  (MUX_BITS)
    ) u_route (
        .src      (src_irq),
        .en       (en_q),
        .fwd      (fwd_q),
        .live     (live),
        .grp_raw  (grp_raw),
        .fwd_raw  (fwd_raw),
        .wake_any (wake_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_irq  <= '0;
            fwd_irq  <= '0;
            wake_req <= 1'b0;
        end else begin
            grp_irq  <= grp_raw;
            fwd_irq  <= fwd_raw;
            wake_req <= suspend & wake_any;
        end
    end

endmodule

// File: rtl/irq_fold_chk.sv
module irq_fold_chk #(
    parameter int          NUM_GRP   = 2,
    parameter int          NUM_MUX   = 3,
    parameter logic [31:0] CONN_MASK = 32'h0000_0FFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MUX-1:0] src_lo,
    input logic               suspend,
    input logic [31:0]        en_q,
    input logic [31:0]        fwd_q,
    input logic [31:0]        reg_rdata,
    input logic [NUM_GRP-1:0] grp_irq,
    input logic [NUM_MUX-1:0] fwd_irq,
    input logic               wake_req
);

    localparam logic [31:0] MUX_BITS = 32'((64'd1 << NUM_MUX) - 64'd1);

    AST_RDATA_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CONN_MASK) == 32'h0);                                    // R3

    AST_FWD_WRITABLE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_q & ~MUX_BITS) == 32'h0);                                         // R6

    AST_GRP_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 32'h0) |=> (grp_irq == '0));                                  // R5

    AST_WAKE_NEEDS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend |=> !wake_req);                                               // R9

    AST_FWD_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fwd_irq == $past(src_lo & fwd_q[NUM_MUX-1:0])));             // R7

    AST_FWD_QUIET_WHEN_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_q[NUM_MUX-1:0] == '0) |=> (fwd_irq == '0));                       // R8

endmodule

bind irq_fold_top irq_fold_chk #(
    .NUM_GRP   (NUM_GRP),
    .NUM_MUX   (NUM_MUX),
    .CONN_MASK (CONN_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lo    (src_irq[NUM_MUX-1:0]),
    .suspend   (suspend),
    .en_q      (en_q),
    .fwd_q     (fwd_q),
    .reg_rdata (reg_rdata),
    .grp_irq   (grp_irq),
    .fwd_irq   (fwd_irq),
    .wake_req  (wake_req)
);

// File: tb/sim_irq_fold_top.sv
module sim_irq_fold_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic        suspend = 1'b0;
    logic        reg_wen = 1'b0;
    logic        reg_ren = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  grp_irq;
    logic [2:0]  fwd_irq;
    logic        wake_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_fold_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .suspend   (suspend),
        .reg_wen   (reg_wen),
        .reg_ren   (reg_ren),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .grp_irq   (grp_irq),
        .fwd_irq   (fwd_irq),
        .wake_req  (wake_req)
    );

    // Reference model of the group outputs, from the requirements
    function automatic logic [1:0] model_grp(input logic [31:0] s, input logic [31:0] e,
                                             input logic [31:0] f);
        logic [31:0] act;
        act = s & 32'hFFF & ~(f & 32'h7) & e;
        return {|(act & 32'h140), |(act & 32'hEBF)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_ren = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_ren = 1'b0;
        d = reg_rdata;
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(negedge clk);
        src_irq = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 grp", 32'(grp_irq), 0);
        chk("R1 fwd_irq", 32'(fwd_irq), 0);
        chk("R1 wake", 32'(wake_req), 0);
        chk("R1 rdata", reg_rdata, 0);
        rd(4'h0, d); chk("R1 enable", d, 0);
        rd(4'h8, d); chk("R1 forward", d, 32'h7);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R2 R3 enable all ones", d, 32'hFFF);
        wr(4'h0, 32'hA5A5_0A5A);
        rd(4'h0, d); chk("R2 enable pattern", d, 32'h0000_0A5A);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        drive_src(32'hFFFF_FFFF);
        rd(4'h4, d); chk("R4 R7 status live", d, 32'hFF8);
        chk("R5 no group when disabled", 32'(grp_irq), 0);
        chk("R7 forwarded while disabled", 32'(fwd_irq), 32'h7);
        wr(4'h4, 32'h0);
        rd(4'h4, d); chk("R4 status after write", d, 32'hFF8);
        rd(4'h0, d); chk("R4 enable untouched", d, 0);
        drive_src(32'h0);
    endtask

    task automatic t_groups();
        logic [31:0] en;
        en = 32'hFFF;
        wr(4'h0, en);
        drive_src(32'h40);
        chk("R5 line 6 -> group 1", 32'(grp_irq), 32'(model_grp(32'h40, en, 7)));
        drive_src(32'h8);
        chk("R5 line 3 -> group 0", 32'(grp_irq), 32'(model_grp(32'h8, en, 7)));
        drive_src(32'h1);
        chk("R7 forwarded line out of groups", 32'(grp_irq), 0);
        chk("R7 forwarded output", 32'(fwd_irq), 32'h1);
        drive_src(32'h0000_1000);
        chk("R3 unconnected line", 32'(grp_irq), 0);
        en = 32'hEB8 & ~32'h200;
        wr(4'h0, en);
        drive_src(32'h200);
        chk("R5 in mask but disabled", 32'(grp_irq), 0);
        drive_src(32'h300);
        chk("R5 two sources", 32'(grp_irq), 32'(model_grp(32'h300, en, 7)));
        wr(4'h0, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_fwd_cfg();
        logic [31:0] d;
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); chk("R6 forward writable bits", d, 32'h7);
        wr(4'h8, 32'h0);
        rd(4'h8, d); chk("R6 forward cleared", d, 0);
        drive_src(32'h2);
        chk("R8 folded line no bypass", 32'(fwd_irq), 0);
        chk("R8 folded line disabled", 32'(grp_irq), 0);
        rd(4'h4, d); chk("R8 folded line in status", d, 32'h2);
        wr(4'h0, 32'h2);
        drive_src(32'h2);
        chk("R8 folded line -> group 0", 32'(grp_irq), 32'(model_grp(32'h2, 32'h2, 0)));
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h7);
        drive_src(32'h0);
    endtask

    task automatic t_wake();
        wr(4'h0, 32'h41);
        drive_src(32'h40);
        chk("R9 no wake without suspend", 32'(wake_req), 0);
        @(negedge clk); suspend = 1'b1;
        @(negedge clk);
        chk("R9 wake in suspend", 32'(wake_req), 1);
        drive_src(32'h1);
        chk("R9 forwarded line no wake", 32'(wake_req), 0);
        @(negedge clk); suspend = 1'b0;
        wr(4'h0, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_badaddr();
        logic [31:0] d;
        wr(4'h0, 32'h123);
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'hC, d); chk("R10 unmapped reads zero", d, 0);
        rd(4'h0, d); chk("R10 enable kept", d, 32'h123);
        rd(4'h8, d); chk("R10 forward kept", d, 32'h7);
        @(negedge clk);
        chk("R10 rdata holds", reg_rdata, 32'h7);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_status();
        t_groups();
        t_fwd_cfg();
        t_wake();
        t_badaddr();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule